// File: doc/BRIEF.md
# Video DRAM Access Sequencer

This block drives a field store built from two 4-bit video DRAMs wired side by side, so the store behaves as one memory with 8-bit words. It shares a single 9-bit multiplexed address bus between rows and columns. It produces the active-low row strobe, column strobe, write enable and data-transfer strobe. It also produces the serial shift clock that empties the serial port after a transfer.

Four sources compete for the memory. A read transfer feeds the display path. A refresh request comes from an internal line counter. The main and sub acquisition channels each issue page-write bursts. A fixed-priority arbiter chooses one source, and a cycle state machine then plays out the fixed waveform for that cycle type. Every cycle is followed by an idle gap of at least `IDLE_MIN` clocks. During that gap all strobes are high. A new cycle can only start from this idle state.

A requester holds its request, row, column and data steady until the sequencer samples them. It then waits for its one-clock acknowledge. Write data for a whole burst is presented as one wide word.

Top module: `vdram_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the four strobes are high, the shift clock is low, the address and write data are zero, and all acknowledges and `ser_valid` are low.
- R2: Outside a memory cycle the sequencer is idle: strobes high, shift clock low, address and write data zero. No memory cycle starts until `IDLE_MIN` idle clocks have passed since reset or since the previous cycle ended.
- R3: When several sources wait at the moment of choice, the winner is decided by a fixed priority. From highest to lowest the order is read transfer, refresh, main write, sub write.
- R4: A write lasts 2+2·`BURST_LEN` clocks. It drives the row for one clock with all strobes high, then drives the row with RAS low for one clock. For each column k it gives one setup clock and then one clock with CAS low. The column address is (start + k) mod 2^`ADDR_W`, WE is low and `mem_dout` carries bits [8k+7:8k] of the latched write word. RAS stays low throughout.
- R5: A read transfer drives the row for one clock, then the row with RAS low, then the column with RAS and DT low for one setup clock, then one clock with CAS low as well. WE stays high.
- R6: After the transfer come `SHIFT_LEN` shift pulses, each one clock high and one clock low, with all strobes high. The byte on `mem_din` at the end of every high clock appears on `ser_data` in the next clock, with `ser_valid` high for exactly that clock.
- R7: Every `LINES_PER_REF`-th `line_tick` pulse sets a pending refresh, which stays set until it is served. A refresh is CAS-before-RAS: one clock with CAS low, one clock with both low, then one clock with only RAS low. WE stays high and the address is zero.
- R8: `main_ack` or `sub_ack` pulses for one clock during the last CAS-low clock of that channel's burst. `rd_ack` pulses during the last shift-low clock. At most one acknowledge is high at any time.
- R9: Row, column and write data are latched when a request is granted. Changing them during the burst has no effect on the address or data pins.
- R10: When requests are already waiting as a cycle ends, the next cycle starts after exactly `IDLE_MIN` idle clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_tick | input | 1 | One-clock pulse per video line |
| main_req | input | 1 | Main channel write request, held until acknowledged |
| main_row | input | ADDR_W | Main write row |
| main_col | input | ADDR_W | Main write start column |
| main_wdata | input | BURST_LEN*DATA_W | Main burst data, byte k in bits [8k+7:8k] |
| main_ack | output | 1 | Main burst finished |
| sub_req | input | 1 | Sub channel write request |
| sub_row | input | ADDR_W | Sub write row |
| sub_col | input | ADDR_W | Sub write start column |
| sub_wdata | input | BURST_LEN*DATA_W | Sub burst data |
| sub_ack | output | 1 | Sub burst finished |
| rd_req | input | 1 | Read transfer request |
| rd_row | input | ADDR_W | Transfer row |
| rd_col | input | ADDR_W | Serial start column |
| rd_ack | output | 1 | Transfer and shifting finished |
| mem_addr | output | ADDR_W | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dt_n | output | 1 | Data transfer strobe, active low |
| mem_sc | output | 1 | Serial shift clock |
| mem_dout | output | DATA_W | Write data to the memory |
| mem_din | input | DATA_W | Serial data from the memory |
| ser_data | output | DATA_W | Captured serial byte |
| ser_valid | output | 1 | ser_data holds a new byte |

## Verification
If the state register or the beat counter gets out of step, it shows up on the strobe pins in the very next clock. Typical symptoms are a CAS pulse that is missing or doubled, RAS released early, or an acknowledge on the wrong beat. A corrupted row, column or data latch shows up on `mem_addr` or `mem_dout` in the first clock that drives it. Idle-counter or arbiter faults show up as a cycle that starts one clock early or late, or as the wrong kind of cycle after the gap. A refresh counter fault appears as a refresh waveform that comes at the wrong line count.

// File: rtl/vdram_pkg.sv
package vdram_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS,
        ST_CSET,
        ST_CPUL,
        ST_SCHI,
        ST_SCLO,
        ST_FCAS,
        ST_FRAS,
        ST_FREL
    } cyc_state_e;

    // Encoding equals arbitration rank: 0 wins.
    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_REFRESH = 2'd1,
        OP_MAIN    = 2'd2,
        OP_SUB     = 2'd3
    } op_kind_e;

    localparam int unsigned NUM_OPS = 4;

endpackage

// File: rtl/vdram_arbiter.sv
module vdram_arbiter #(
    parameter int unsigned N = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] pick
);

    // Scan from lowest rank to highest so the lowest index wins.
    always_comb begin
        any  = |req;
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vdram_refresh_timer.sv
module vdram_refresh_timer #(
    parameter int unsigned LINES_PER_REF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic clr,
    output logic pend
);

    localparam int unsigned CW = (LINES_PER_REF > 1) ? $clog2(LINES_PER_REF) : 1;
    localparam logic [CW-1:0] LAST = CW'(LINES_PER_REF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t tmr_q, tmr_d;
    logic wrap;

    always_comb begin
        tmr_d = tmr_q;
        wrap  = line_tick && (tmr_q.cnt == LAST);
        if (line_tick) begin
            tmr_d.cnt = wrap ? '0 : tmr_q.cnt + 1'b1;
        end
        tmr_d.pend = (tmr_q.pend && !clr) || wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign pend = tmr_q.pend;

    // R7: a pending refresh is only dropped by being served
    p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);

endmodule

// File: rtl/vdram_serial_capture.sv
module vdram_serial_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] ser_data,
    output logic              ser_valid
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } cap_t;

    cap_t cap_q, cap_d;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = sc;
        if (sc) begin
            cap_d.data = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign ser_data  = cap_q.data;
    assign ser_valid = cap_q.valid;

    // R6: a captured byte is only reported after a high shift clock
    p_valid_after_sc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> $past(sc));

endmodule

// File: rtl/vdram_seq.sv
module vdram_seq
    import vdram_pkg::*;
#(
    parameter int unsigned ADDR_W        = 9,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned BURST_LEN     = 4,
    parameter int unsigned SHIFT_LEN     = 4,
    parameter int unsigned IDLE_MIN      = 4,
    parameter int unsigned LINES_PER_REF = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          line_tick,
    input  logic                          main_req,
    input  logic [ADDR_W-1:0]             main_row,
    input  logic [ADDR_W-1:0]             main_col,
    input  logic [BURST_LEN*DATA_W-1:0]   main_wdata,
    output logic                          main_ack,
    input  logic                          sub_req,
    input  logic [ADDR_W-1:0]             sub_row,
    input  logic [ADDR_W-1:0]             sub_col,
    input  logic [BURST_LEN*DATA_W-1:0]   sub_wdata,
    output logic                          sub_ack,
    input  logic                          rd_req,
    input  logic [ADDR_W-1:0]             rd_row,
    input  logic [ADDR_W-1:0]             rd_col,
    output logic                          rd_ack,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic                          mem_ras_n,
    output logic                          mem_cas_n,
    output logic                          mem_we_n,
    output logic                          mem_dt_n,
    output logic                          mem_sc,
    output logic [DATA_W-1:0]             mem_dout,
    input  logic [DATA_W-1:0]             mem_din,
    output logic [DATA_W-1:0]             ser_data,
    output logic                          ser_valid
);

    localparam int unsigned WD_W = BURST_LEN * DATA_W;
    localparam int unsigned MAXB = (BURST_LEN > SHIFT_LEN) ? BURST_LEN : SHIFT_LEN;
    localparam int unsigned BW   = (MAXB > 1) ? $clog2(MAXB) : 1;
    localparam int unsigned ICW  = $clog2(IDLE_MIN + 1);
    localparam int unsigned OIW  = $clog2(NUM_OPS);
    localparam logic [BW-1:0]  LAST_WR   = BW'(BURST_LEN - 1);
    localparam logic [BW-1:0]  LAST_SH   = BW'(SHIFT_LEN - 1);
    localparam logic [ICW-1:0] IDLE_LAST = ICW'(IDLE_MIN - 1);

    typedef struct packed {
        cyc_state_e        st;
        op_kind_e          op;
        logic [ICW-1:0]    idle_cnt;
        logic [BW-1:0]     beat;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic [WD_W-1:0]   wdata;
    } seq_t;

    seq_t seq_q, seq_d;

    logic           ref_pend;
    logic           ref_clr;
    logic           gnt_any;
    logic [OIW-1:0] gnt_idx;
    op_kind_e       gnt_op;
    logic           wr_op;

    vdram_refresh_timer #(
        .LINES_PER_REF(LINES_PER_REF)
    ) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_tick(line_tick),
        .clr      (ref_clr),
        .pend     (ref_pend)
    );

    vdram_arbiter #(
        .N(NUM_OPS)
    ) u_arb (
        .req ({sub_req, main_req, ref_pend, rd_req}),
        .any (gnt_any),
        .pick(gnt_idx)
    );

    assign gnt_op = op_kind_e'(gnt_idx);

    // Next-state logic
    always_comb begin
        seq_d   = seq_q;
        ref_clr = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (seq_q.idle_cnt != IDLE_LAST) begin
                    seq_d.idle_cnt = seq_q.idle_cnt + 1'b1;
                end
                if ((seq_q.idle_cnt == IDLE_LAST) && gnt_any) begin
                    seq_d.idle_cnt = '0;
                    seq_d.beat     = '0;
                    seq_d.op       = gnt_op;
                    seq_d.wdata    = (gnt_op == OP_SUB) ? sub_wdata : main_wdata;
                    seq_d.st       = (gnt_op == OP_REFRESH) ? ST_FCAS : ST_ROW;
                    unique case (gnt_op)
                        OP_READ: begin
                            seq_d.row = rd_row;
                            seq_d.col = rd_col;
                        end
                        OP_MAIN: begin
                            seq_d.row = main_row;
                            seq_d.col = main_col;
                        end
                        OP_SUB: begin
                            seq_d.row = sub_row;
                            seq_d.col = sub_col;
                        end
                        default: begin
                            seq_d.row = '0;
                            seq_d.col = '0;
                            ref_clr   = 1'b1;
                        end
                    endcase
                end
            end
            ST_ROW:  seq_d.st = ST_RAS;
            ST_RAS:  seq_d.st = ST_CSET;
            ST_CSET: seq_d.st = ST_CPUL;
            ST_CPUL: begin
                if (seq_q.op == OP_READ) begin
                    seq_d.st   = ST_SCHI;
                    seq_d.beat = '0;
                end else if (seq_q.beat == LAST_WR) begin
                    seq_d.st = ST_IDLE;
                end else begin
                    seq_d.st   = ST_CSET;
                    seq_d.beat = seq_q.beat + 1'b1;
                end
            end
            ST_SCHI: seq_d.st = ST_SCLO;
            ST_SCLO: begin
                if (seq_q.beat == LAST_SH) begin
                    seq_d.st = ST_IDLE;
                end else begin
                    seq_d.st   = ST_SCHI;
                    seq_d.beat = seq_q.beat + 1'b1;
                end
            end
            ST_FCAS: seq_d.st = ST_FRAS;
            ST_FRAS: seq_d.st = ST_FREL;
            ST_FREL: seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // Pin decode from the registered state
    always_comb begin
        wr_op     = (seq_q.op == OP_MAIN) || (seq_q.op == OP_SUB);
        mem_addr  = '0;
        mem_dout  = '0;
        mem_ras_n = 1'b1;
        mem_cas_n = 1'b1;
        mem_we_n  = 1'b1;
        mem_dt_n  = 1'b1;
        mem_sc    = 1'b0;
        main_ack  = 1'b0;
        sub_ack   = 1'b0;
        rd_ack    = 1'b0;
        unique case (seq_q.st)
            ST_ROW: mem_addr = seq_q.row;
            ST_RAS: begin
                mem_addr  = seq_q.row;
                mem_ras_n = 1'b0;
            end
            ST_CSET, ST_CPUL: begin
                mem_addr  = seq_q.col + ADDR_W'(seq_q.beat);
                mem_ras_n = 1'b0;
                mem_cas_n = (seq_q.st != ST_CPUL);
                if (wr_op) begin
                    mem_we_n = 1'b0;
                    mem_dout = seq_q.wdata[int'(seq_q.beat)*DATA_W +: DATA_W];
                    if ((seq_q.st == ST_CPUL) && (seq_q.beat == LAST_WR)) begin
                        main_ack = (seq_q.op == OP_MAIN);
                        sub_ack  = (seq_q.op == OP_SUB);
                    end
                end else begin
                    mem_dt_n = 1'b0;
                end
            end
            ST_SCHI: mem_sc = 1'b1;
            ST_SCLO: rd_ack = (seq_q.beat == LAST_SH);
            ST_FCAS: mem_cas_n = 1'b0;
            ST_FRAS: begin
                mem_cas_n = 1'b0;
                mem_ras_n = 1'b0;
            end
            ST_FREL: mem_ras_n = 1'b0;
            default: ;
        endcase
    end

    vdram_serial_capture #(
        .DATA_W(DATA_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sc       (mem_sc),
        .din      (mem_din),
        .ser_data (ser_data),
        .ser_valid(ser_valid)
    );

    // Checker state: run of clocks with neither RAS nor CAS low
    logic [ICW-1:0] quiet_q;
    logic           strobe_act;
    assign strobe_act = !mem_ras_n || !mem_cas_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= '0;
        end else if (strobe_act) begin
            quiet_q <= '0;
        end else if (quiet_q != ICW'(IDLE_MIN)) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    p_quiet_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_act && quiet_q != '0) |-> (quiet_q >= ICW'(IDLE_MIN)));

    p_read_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && seq_q.idle_cnt == IDLE_LAST && rd_req)
        |=> (seq_q.op == OP_READ && seq_q.st == ST_ROW));

    p_cas_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cas_n && !mem_we_n) |=> mem_cas_n);

    p_row_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ras_n) && mem_cas_n) |-> $stable(mem_addr));

    p_dt_not_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_dt_n |-> mem_we_n);

    p_sc_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sc |-> (mem_ras_n && mem_cas_n && mem_dt_n && mem_we_n));

    p_cbr_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ras_n) && !mem_cas_n) |-> (!$past(mem_cas_n) && mem_we_n));

    p_ack_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_ack, sub_ack, rd_ack}));

    p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (main_ack || sub_ack || rd_ack) |=> !(main_ack || sub_ack || rd_ack));

endmodule

// File: tb/sim_vdram_seq.sv
module sim_vdram_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 9;
    localparam int DW    = 8;
    localparam int BURST = 4;
    localparam int SHIFT = 4;
    localparam int IDLE  = 4;
    localparam int LPR   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_tick = 1'b0;
    logic main_req = 1'b0, sub_req = 1'b0, rd_req = 1'b0;
    logic [AW-1:0] main_row = '0, main_col = '0, sub_row = '0, sub_col = '0;
    logic [AW-1:0] rd_row = '0, rd_col = '0;
    logic [BURST*DW-1:0] main_wdata = '0, sub_wdata = '0;
    logic main_ack, sub_ack, rd_ack;
    logic [AW-1:0] mem_addr;
    logic mem_ras_n, mem_cas_n, mem_we_n, mem_dt_n, mem_sc;
    logic [DW-1:0] mem_dout;
    logic [DW-1:0] mem_din = 8'h50;
    logic [DW-1:0] ser_data;
    logic ser_valid;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vdram_seq #(
        .ADDR_W(AW), .DATA_W(DW), .BURST_LEN(BURST), .SHIFT_LEN(SHIFT),
        .IDLE_MIN(IDLE), .LINES_PER_REF(LPR)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
        .main_req(main_req), .main_row(main_row), .main_col(main_col),
        .main_wdata(main_wdata), .main_ack(main_ack),
        .sub_req(sub_req), .sub_row(sub_row), .sub_col(sub_col),
        .sub_wdata(sub_wdata), .sub_ack(sub_ack),
        .rd_req(rd_req), .rd_row(rd_row), .rd_col(rd_col), .rd_ack(rd_ack),
        .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_dt_n(mem_dt_n), .mem_sc(mem_sc),
        .mem_dout(mem_dout), .mem_din(mem_din),
        .ser_data(ser_data), .ser_valid(ser_valid)
    );

    int checks = 0;
    int failures = 0;
    bit started = 0;
    bit done = 0;
    bit tick_en = 0;
    bit r9_mode = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected pin state for one clock
    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic ras, cas, we, dt, sc, ma, sa, ra;
        string tag;
    } vec_t;

    vec_t q[$];
    vec_t cur;
    bit cur_idle;
    int m_idle;
    bit m_pend;
    int m_lines;
    bit exp_sv;
    logic [DW-1:0] exp_sd;

    task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic ras, input logic cas, input logic we, input logic dt,
                        input logic sc, input logic ma, input logic sa, input logic ra,
                        input string tag);
        vec_t v;
        v.a = a; v.d = d; v.ras = ras; v.cas = cas; v.we = we; v.dt = dt;
        v.sc = sc; v.ma = ma; v.sa = sa; v.ra = ra; v.tag = tag;
        q.push_back(v);
    endtask

    function automatic vec_t idle_vec(input string tag);
        vec_t v;
        v.a = '0; v.d = '0; v.ras = 1; v.cas = 1; v.we = 1; v.dt = 1;
        v.sc = 0; v.ma = 0; v.sa = 0; v.ra = 0; v.tag = tag;
        return v;
    endfunction

    // R4 / R9 write burst
    task automatic build_write(input bit is_sub, input logic [AW-1:0] row,
                               input logic [AW-1:0] col, input logic [BURST*DW-1:0] data);
        string t;
        t = r9_mode ? "R9" : "R4";
        push(row, 0, 1, 1, 1, 1, 0, 0, 0, 0, "R4");
        push(row, 0, 0, 1, 1, 1, 0, 0, 0, 0, "R4");
        for (int k = 0; k < BURST; k++) begin
            logic [AW-1:0] c;
            logic [DW-1:0] b;
            bit last;
            c = col + AW'(k);
            b = data[k*DW +: DW];
            last = (k == BURST - 1);
            push(c, b, 0, 1, 0, 1, 0, 0, 0, 0, t);
            push(c, b, 0, 0, 0, 1, 0, last && !is_sub, last && is_sub, 0, t);
        end
    endtask

    // R5 transfer then R6 shifting
    task automatic build_read(input logic [AW-1:0] row, input logic [AW-1:0] col);
        push(row, 0, 1, 1, 1, 1, 0, 0, 0, 0, "R5");
        push(row, 0, 0, 1, 1, 1, 0, 0, 0, 0, "R5");
        push(col, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R5");
        push(col, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R5");
        for (int k = 0; k < SHIFT; k++) begin
            push(0, 0, 1, 1, 1, 1, 1, 0, 0, 0, "R6");
            push(0, 0, 1, 1, 1, 1, 0, 0, 0, (k == SHIFT - 1), "R6");
        end
    endtask

    // R7 CAS-before-RAS refresh
    task automatic build_ref();
        push(0, 0, 1, 0, 1, 1, 0, 0, 0, 0, "R7");
        push(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R7");
        push(0, 0, 0, 1, 1, 1, 0, 0, 0, 0, "R7");
    endtask

    // Reference model, advanced on every clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            cur = idle_vec("R1");
            cur_idle = 1;
            m_idle = 0;
            m_pend = 0;
            m_lines = 0;
            exp_sv = 0;
            exp_sd = '0;
        end else begin
            bit gref;
            bit set;
            int n;
            if (cur.sc) begin
                exp_sv = 1;
                exp_sd = mem_din;
            end else begin
                exp_sv = 0;
            end
            if (cur_idle) m_idle++;
            gref = 0;
            n = int'(rd_req) + int'(m_pend) + int'(main_req) + int'(sub_req);
            if (q.size() > 0) begin
                cur = q.pop_front();
                cur_idle = 0;
            end else if (m_idle >= IDLE && n > 0) begin
                if (rd_req) build_read(rd_row, rd_col);
                else if (m_pend) begin build_ref(); gref = 1; end
                else if (main_req) build_write(0, main_row, main_col, main_wdata);
                else build_write(1, sub_row, sub_col, sub_wdata);
                if (n > 1) q[0].tag = "R3";
                cur = q.pop_front();
                cur_idle = 0;
                m_idle = 0;
            end else begin
                cur = idle_vec((n > 0) ? "R10" : "R2");
                cur_idle = 1;
            end
            set = 0;
            if (line_tick) begin
                if (m_lines == LPR - 1) begin
                    m_lines = 0;
                    set = 1;
                end else begin
                    m_lines++;
                end
            end
            m_pend = (m_pend && !gref) || set;
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && started && !done) begin
            check(cur.tag,
                  64'({mem_addr, mem_dout, mem_ras_n, mem_cas_n, mem_we_n, mem_dt_n, mem_sc}),
                  64'({cur.a, cur.d, cur.ras, cur.cas, cur.we, cur.dt, cur.sc}));
            check("R8", 64'({main_ack, sub_ack, rd_ack}), 64'({cur.ma, cur.sa, cur.ra}));
            if (exp_sv) check("R6", 64'({ser_valid, ser_data}), 64'({1'b1, exp_sd}));
            else        check("R6", 64'(ser_valid), 64'(0));
        end
    end

    // Serial port model: next byte after each completed shift pulse
    bit sc_prev = 0;
    int nsc = 0;
    always @(negedge clk) begin
        if (sc_prev && !mem_sc) begin
            nsc++;
            mem_din <= 8'h50 + DW'(nsc * 3);
        end
        sc_prev = mem_sc;
    end

    // Line pulses
    initial begin
        forever begin
            repeat (37) @(negedge clk);
            if (tick_en) line_tick = 1'b1;
            @(negedge clk);
            line_tick = 1'b0;
        end
    end

    task automatic do_main(input logic [AW-1:0] row, input logic [AW-1:0] col,
                           input logic [BURST*DW-1:0] data);
        @(negedge clk);
        main_req = 1; main_row = row; main_col = col; main_wdata = data;
        do @(negedge clk); while (!main_ack);
        main_req = 0;
    endtask

    task automatic do_sub(input logic [AW-1:0] row, input logic [AW-1:0] col,
                          input logic [BURST*DW-1:0] data);
        @(negedge clk);
        sub_req = 1; sub_row = row; sub_col = col; sub_wdata = data;
        do @(negedge clk); while (!sub_ack);
        sub_req = 0;
    endtask

    task automatic do_read(input logic [AW-1:0] row, input logic [AW-1:0] col);
        @(negedge clk);
        rd_req = 1; rd_row = row; rd_col = col;
        do @(negedge clk); while (!rd_ack);
        rd_req = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", 64'({mem_addr, mem_dout, mem_ras_n, mem_cas_n, mem_we_n, mem_dt_n, mem_sc}),
              64'({9'd0, 8'd0, 4'b1111, 1'b0}));
        check("R1", 64'({main_ack, sub_ack, rd_ack, ser_valid}), 64'(0));
        rst_n = 1;
        @(posedge clk);
        started = 1;

        // R4 with column wrap, then sub channel, then R5/R6 transfer
        do_main(9'h012, 9'h1FE, 32'h44332211);
        do_sub(9'h1A0, 9'h040, 32'hDDCCBBAA);
        do_read(9'h0AB, 9'h010);

        // R7: refreshes from line pulses
        tick_en = 1;
        repeat (400) @(negedge clk);

        // R3: everything at once, R10: back-to-back with waiting requests
        fork
            do_main(9'h003, 9'h100, 32'h0F0E0D0C);
            do_sub(9'h004, 9'h101, 32'h1B1A1918);
            do_read(9'h005, 9'h0FF);
        join
        fork
            do_sub(9'h006, 9'h020, 32'h77665544);
            do_main(9'h007, 9'h021, 32'h3C2B1A09);
        join

        // R9: inputs change mid-burst
        r9_mode = 1;
        fork
            do_main(9'h0C0, 9'h0C4, 32'hA5B6C7D8);
            begin
                do @(negedge clk); while (mem_ras_n);
                main_col = 9'h1FF;
                main_row = 9'h1FF;
                main_wdata = 32'hFFFFFFFF;
            end
        join
        r9_mode = 0;

        tick_en = 0;
        repeat (60) @(negedge clk);
        finish_run();
    end

endmodule